// File: doc/BRIEF.md
# Armed Pulse Catcher With Return-To-Zero Handshake

This block turns a short-lived, possibly glitchy level on `raw_in` into a steady output that the rest of the chip can rely on. A requester raises `arm_req` to say that it wants to know when `raw_in` goes high. From then on, the first high level on `raw_in` is caught and, once synchronized, drives `held_out` high. `held_out` then stays high no matter what `raw_in` does. The requester acknowledges by lowering `arm_req`, which drops `held_out` and leaves the block dormant. While dormant, `raw_in` cannot disturb anything.

The capture flop is set asynchronously by `raw_in` while the block is armed, so pulses far shorter than a clock period are not lost. A two-stage synchronizer brings the caught level into the clock domain. `arm_req` is treated as a signal of the clock domain. If the requester withdraws `arm_req` before `held_out` has risen, `proto_err` pulses for one cycle to flag the broken handshake.

Top module: `wait_catcher`

## Requirements
- R1: During and right after a synchronous active-high `rst`, `held_out` and `proto_err` are 0.
- R2: With `arm_req` high, a high level on `raw_in` makes `held_out` 1 no later than the third rising clock edge after it. `held_out` then stays 1 for as long as `arm_req` stays high, whatever `raw_in` does.
- R3: With `arm_req` high, a `raw_in` pulse shorter than one clock period that falls between clock edges still sets `held_out`.
- R4: Activity on `raw_in` while `arm_req` is low has no effect. `held_out` stays 0 then, and it stays 0 after a later arming when `raw_in` stays low.
- R5: `held_out` is 0 after the first rising edge at which `arm_req` is sampled low.
- R6: `proto_err` is 1 for exactly one cycle, after the edge that first samples `arm_req` low, when `held_out` was still 0 at that point. It stays 0 when `arm_req` falls after `held_out` has risen.
- R7: After a complete handshake (arm, capture, disarm, release), a new arming captures a new `raw_in` pulse in the same way.
- R8: If `raw_in` is already high at the moment `arm_req` rises, that level is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm_req | input | 1 | Request: high arms the catcher, low acknowledges and makes it dormant |
| raw_in | input | 1 | Non-persistent input level to be caught |
| held_out | output | 1 | Persistent captured level |
| proto_err | output | 1 | One-cycle flag: request withdrawn before capture |

## Verification
The bench drives `raw_in` with three shapes inside an armed window: sub-cycle pulses placed between edges, levels held for several cycles, and a level that is already high when arming starts. The first shape tells an asynchronous catch apart from plain sampling. The second checks that the output holds while `raw_in` keeps toggling. The third checks capture on the arming edge itself. Dormant-window pulses followed by a silent armed window show that dormant activity leaves nothing behind. Random rounds that contain no pulse separate the flagged early withdrawal from the clean release.

// File: rtl/wait_pkg.sv
package wait_pkg;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic held;
        logic err;
        logic arm_d;
    } hs_state_t;

    // Next handshake state from the current state, request and synced capture.
    function automatic hs_state_t hs_next(hs_state_t cur, logic arm, logic seen);
        hs_state_t nxt;
        nxt.arm_d = arm;
        nxt.held  = arm & (cur.held | seen);
        nxt.err   = cur.arm_d & ~arm & ~cur.held;
        return nxt;
    endfunction
endpackage

// File: rtl/wait_pulse_catch.sv
module wait_pulse_catch (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic din,
    output logic caught
);
    logic set_p;
    assign set_p = din & arm & ~rst;

    always_ff @(posedge clk or posedge set_p) begin
        if (set_p)
            caught <= 1'b1;
        else if (rst || !arm)
            caught <= 1'b0;
    end
endmodule

// File: rtl/wait_sync.sv
module wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] st;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) st[i] <= clr ? 1'b0 : d;
        end else begin : g_rest
            always_ff @(posedge clk) st[i] <= clr ? 1'b0 : st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/wait_hs.sv
module wait_hs
    import wait_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic seen,
    output logic held,
    output logic err
);
    hs_state_t st;

    always_ff @(posedge clk) begin
        if (rst)
            st <= '0;
        else
            st <= hs_next(st, arm, seen);
    end

    assign held = st.held;
    assign err  = st.err;
endmodule

// File: rtl/wait_catcher.sv
module wait_catcher
    import wait_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm_req,
    input  logic raw_in,
    output logic held_out,
    output logic proto_err
);
    logic caught;
    logic seen;
    logic sync_clr;

    assign sync_clr = rst | ~arm_req;

    wait_pulse_catch u_catch (
        .clk    (clk),
        .rst    (rst),
        .arm    (arm_req),
        .din    (raw_in),
        .caught (caught)
    );

    wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .clr (sync_clr),
        .d   (caught),
        .q   (seen)
    );

    wait_hs u_hs (
        .clk  (clk),
        .rst  (rst),
        .arm  (arm_req),
        .seen (seen),
        .held (held_out),
        .err  (proto_err)
    );
endmodule

// File: rtl/wait_catcher_chk.sv
module wait_catcher_chk (
    input logic clk,
    input logic rst,
    input logic arm_req,
    input logic raw_in,
    input logic held_out,
    input logic proto_err
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!held_out && !proto_err)); // R1
    AST_HOLD_WHILE_ARMED: assert property (@(posedge clk) disable iff (rst)
        (held_out && arm_req) |=> held_out); // R2
    AST_DORMANT_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(held_out) |-> $past(arm_req)); // R4
    AST_RELEASE_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        !arm_req |=> !held_out); // R5
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> !proto_err); // R6
    AST_ERR_NOT_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (held_out && arm_req) |=> !proto_err); // R6
endmodule

bind wait_catcher wait_catcher_chk u_chk (.*);

// File: tb/wait_catcher_bench.sv
`timescale 1ns/100ps
module wait_catcher_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm_req = 1'b0;
    logic raw_in = 1'b0;
    logic held_out, proto_err;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wait_catcher u_wait_catcher (
        .clk(clk), .rst(rst), .arm_req(arm_req), .raw_in(raw_in),
        .held_out(held_out), .proto_err(proto_err)
    );

    // Expected values from the requirements.
    function automatic bit exp_held(bit got_pulse);
        return got_pulse;
    endfunction
    function automatic bit exp_err_on_drop(bit got_pulse);
        return !got_pulse;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic short_pulse(real w);
        #0.3 raw_in = 1'b1;
        #(w) raw_in = 1'b0;
    endtask

    // Drop the request and check the release and flag timing (R5, R6).
    task automatic disarm(bit got_pulse);
        arm_req = 1'b0;
        cyc(1);
        chk("R5 release", held_out, 1'b0);
        chk("R6 flag", proto_err, exp_err_on_drop(got_pulse));
        cyc(1);
        chk("R6 single", proto_err, 1'b0);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        cyc(3);
        chk("R1 held", held_out, 1'b0);
        chk("R1 err", proto_err, 1'b0);
        rst = 1'b0;
        cyc(2);
        chk("R1 after", held_out, 1'b0);

        // R3 sub-cycle pulse
        arm_req = 1'b1;
        cyc(2);
        short_pulse(0.5);
        cyc(4);
        chk("R3 short pulse", held_out, 1'b1);
        // R2 hold while raw_in toggles
        for (int k = 0; k < 4; k++) begin
            raw_in = ~raw_in;
            cyc(1);
            chk("R2 hold", held_out, 1'b1);
        end
        raw_in = 1'b0;
        disarm(1'b1);

        // R4 dormant pulses, then silent arming
        short_pulse(0.8);
        cyc(1);
        raw_in = 1'b1; cyc(3); raw_in = 1'b0;
        chk("R4 dormant", held_out, 1'b0);
        arm_req = 1'b1;
        cyc(5);
        chk("R4 silent arm", held_out, 1'b0);
        disarm(1'b0);

        // R8 level already high at arming
        raw_in = 1'b1;
        cyc(1);
        arm_req = 1'b1;
        #0.5 raw_in = 1'b0;
        cyc(4);
        chk("R8 pre-high", held_out, 1'b1);
        disarm(1'b1);

        // R2 multi-cycle level; R7 re-arm after complete handshake
        arm_req = 1'b1;
        cyc(1);
        raw_in = 1'b1; cyc(2); raw_in = 1'b0;
        cyc(2);
        chk("R2 level", held_out, 1'b1);
        disarm(1'b1);
        arm_req = 1'b1;
        cyc(2);
        short_pulse(0.4);
        cyc(4);
        chk("R7 rearm", held_out, 1'b1);
        disarm(1'b1);

        // Random rounds
        for (int r = 0; r < 200; r++) begin
            bit dorm, pulse, is_short;
            dorm = $urandom_range(0, 1);
            pulse = $urandom_range(0, 1);
            is_short = $urandom_range(0, 1);
            if (dorm) begin
                short_pulse(0.2 + 0.1 * $urandom_range(0, 10));
                cyc(1);
                chk("R4 random dormant", held_out, 1'b0);
            end
            arm_req = 1'b1;
            cyc($urandom_range(1, 4));
            if (pulse) begin
                if (is_short)
                    short_pulse(0.2 + 0.1 * $urandom_range(0, 10));
                else begin
                    raw_in = 1'b1;
                    cyc($urandom_range(1, 5));
                    raw_in = 1'b0;
                end
            end
            cyc(4);
            chk(is_short ? "R3 random" : "R2 random", held_out, exp_held(pulse));
            disarm(pulse);
            cyc($urandom_range(0, 2));
        end
        done = 1'b1;
    end

    initial begin
        int wd;
        wd = 0;
        while (!done && wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule